// File: doc/BRIEF.md
# USB Host Power and Port Control Registers

This block is a small register file placed next to a USB host controller core. Software uses it to take the controller IP through soft reset, to power the host and device halves of the IP up and down, and to configure each SuperSpeed and high-speed port (disable, power-down, host select). A read-only capability word reports how many ports of each kind exist. A read-only status word shows when the system PLL has settled, when each clock-domain reset has been released, and when the IP has entered sleep.

The clock generator and the sleep handshake are not present here. Internal counters model them. Clearing host power-down starts a settle count. When the count ends, PLL-stable is raised, and the three reset-released flags then follow one after another at a fixed spacing. Sleep is reported only after every power-down condition has held for a set number of cycles. Access uses a plain 32-bit bus: a byte address, a write strobe, write data, and combinational read data.

Top module: `usbh_pwr_regs`

## Requirements
- R1: After reset, address 0x00 reads 0 and 0x04 (host power-down) reads 1. Address 0x08 (device power-down) reads 0 and 0x0C (status) reads 0. Every existing port register reads 3 (disabled and powered down).
- R2: Address 0x10 is read-only. It returns the high-speed port count in bits [15:8] and the SuperSpeed port count in bits [7:0], with zeros above. Writes to it have no effect.
- R3: Only bit 0 is stored at addresses 0x00 (soft reset), 0x04 (host power-down) and 0x08 (device power-down). The other bits of these registers read 0.
- R4: SuperSpeed port i sits at 0x40+4i and high-speed port i at 0x60+4i. Each holds bit 0 = disable, bit 1 = power-down and bit 2 = host select. Bits above 2 read 0.
- R5: Port slots at or beyond the configured count read 0 and ignore writes. Undefined addresses read 0.
- R6: Status bit 0 (PLL stable) rises PLL_DLY clock edges after the edge that wrote host power-down to 0.
- R7: Status bits 8, 10 and 11 (reference, system and controller domain resets released) rise RST_STEP, 2*RST_STEP and 3*RST_STEP edges after bit 0.
- R8: Status bits 0, 8, 10 and 11 read 0 from the edge that writes host power-down to 1. This holds even when that edge coincides with a bit's rise.
- R9: Status bit 30 (IP sleep) is 1 only when host power-down, device power-down and every existing port's power-down bit have all been set for SLEEP_DLY edges. It drops as soon as any of them clears.
- R10: While soft reset (0x00 bit 0) is 1, every other register is returned to its reset value one edge later and ignores writes. Writing 0 to bit 0 ends soft reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Two events can fall in the same edge: a write that sets host power-down, and the settle counter reaching the point where PLL-stable would rise. The bench clears power-down, waits exactly PLL_DLY-1 cycles, and then writes power-down back to 1. The status word must read 0 immediately after that edge and must stay 0 afterwards. In a similar way, a port write that removes one sleep condition lands while sleep is reported, and the sleep bit must drop in the same cycle.

// File: rtl/usbh_pwr_pkg.sv
package usbh_pwr_pkg;
  // word indices (byte address >> 2)
  localparam int W_SRST = 'h00;
  localparam int W_HPD  = 'h01;
  localparam int W_DPD  = 'h02;
  localparam int W_STS  = 'h03;
  localparam int W_CAP  = 'h04;
  localparam int W_SS_BASE = 'h10;
  localparam int W_HS_BASE = 'h18;
  localparam int SLOT_MAX  = 8;

  // status bit positions
  localparam int STS_PLL = 0;
  localparam int STS_REF = 8;
  localparam int STS_SYS = 10;
  localparam int STS_CTL = 11;
  localparam int STS_SLP = 30;

  // port control fields
  localparam int PC_DIS  = 0;
  localparam int PC_PD   = 1;
  localparam int PC_HSEL = 2;
  localparam int PC_W    = 3;
  localparam logic [PC_W-1:0] PC_RST_VAL = 3'b011;
endpackage

// File: rtl/usbh_port_bank.sv
module usbh_port_bank
  import usbh_pwr_pkg::*;
#(
  parameter int NPORT  = 2,
  parameter int BASE_W = 'h18,
  parameter int WORD_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    srst,
  input  logic                    wr,
  input  logic [WORD_W-1:0]       wword,
  input  logic [PC_W-1:0]         wbits,
  output logic [NPORT*PC_W-1:0]   ctl_flat,
  output logic                    pd_all
);
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic [PC_W-1:0] ctl_q, ctl_n;
    logic            hit;

    assign hit = wr && (wword == WORD_W'(BASE_W + g));

    always_comb begin
      ctl_n = ctl_q;
      if (srst)     ctl_n = PC_RST_VAL;
      else if (hit) ctl_n = wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= PC_RST_VAL;
      else        ctl_q <= ctl_n;
    end

    assign ctl_flat[g*PC_W +: PC_W] = ctl_q;

    assert_port_srst_R10: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (ctl_flat[g*PC_W +: PC_W] == PC_RST_VAL));
  end

  always_comb begin
    pd_all = 1'b1;
    for (int i = 0; i < NPORT; i++) pd_all = pd_all & ctl_flat[i*PC_W + PC_PD];
  end
endmodule

// File: rtl/usbh_pwr_seq.sv
module usbh_pwr_seq #(
  parameter int PLL_DLY   = 64,
  parameter int RST_STEP  = 4,
  parameter int SLEEP_DLY = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic host_pd,
  input  logic sleep_cond,
  output logic pll_ok,
  output logic ref_ok,
  output logic sys_ok,
  output logic ctl_ok,
  output logic sleep
);
  localparam int UP_MAX = PLL_DLY + 3*RST_STEP;
  localparam int UP_W   = $clog2(UP_MAX + 1);
  localparam int SL_W   = $clog2(SLEEP_DLY + 1);
  localparam logic [UP_W-1:0] UP_TOP = UP_W'(UP_MAX);
  localparam logic [UP_W-1:0] TH_PLL = UP_W'(PLL_DLY);
  localparam logic [UP_W-1:0] TH_REF = UP_W'(PLL_DLY + RST_STEP);
  localparam logic [UP_W-1:0] TH_SYS = UP_W'(PLL_DLY + 2*RST_STEP);
  localparam logic [SL_W-1:0] SL_TOP = SL_W'(SLEEP_DLY);

  logic [UP_W-1:0] up_q, up_n;
  logic [SL_W-1:0] sl_q, sl_n;

  always_comb begin
    if (host_pd || srst)  up_n = '0;
    else if (up_q == UP_TOP) up_n = up_q;
    else                  up_n = up_q + 1'b1;
    if (!sleep_cond || srst) sl_n = '0;
    else if (sl_q == SL_TOP) sl_n = sl_q;
    else                  sl_n = sl_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      sl_q <= '0;
    end else begin
      up_q <= up_n;
      sl_q <= sl_n;
    end
  end

  assign pll_ok = !host_pd && (up_q >= TH_PLL);
  assign ref_ok = !host_pd && (up_q >= TH_REF);
  assign sys_ok = !host_pd && (up_q >= TH_SYS);
  assign ctl_ok = !host_pd && (up_q == UP_TOP);
  assign sleep  = sleep_cond && (sl_q == SL_TOP);

  assert_pll_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_ok) |-> $past(!host_pd));
  assert_ref_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ok |-> pll_ok);
  assert_sys_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ok |-> ref_ok);
  assert_ctl_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ok |-> sys_ok);
  assert_pd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_pd |-> !(pll_ok || ref_ok || sys_ok || ctl_ok));
  assert_sleep_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> sleep_cond);
  assert_sleep_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> $past(sleep_cond));
endmodule

// File: rtl/usbh_pwr_regs.sv
module usbh_pwr_regs
  import usbh_pwr_pkg::*;
#(
  parameter int SS_PORTS  = 1,
  parameter int HS_PORTS  = 2,
  parameter int PLL_DLY   = 64,
  parameter int RST_STEP  = 4,
  parameter int SLEEP_DLY = 32,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int WORD_W = ADDR_W - 2;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic [WORD_W-1:0] word;
  assign word = bus_addr[ADDR_W-1:2];

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:PC_W]};

  // top-level control bits
  logic srst_q, srst_n, hpd_q, hpd_n, dpd_q, dpd_n;
  logic wr_srst, wr_hpd, wr_dpd;
  assign wr_srst = bus_wr && (word == WORD_W'(W_SRST));
  assign wr_hpd  = bus_wr && (word == WORD_W'(W_HPD));
  assign wr_dpd  = bus_wr && (word == WORD_W'(W_DPD));

  always_comb begin
    srst_n = wr_srst ? bus_wdata[0] : srst_q;
    hpd_n  = hpd_q;
    dpd_n  = dpd_q;
    if (srst_q) begin
      hpd_n = 1'b1;
      dpd_n = 1'b0;
    end else begin
      if (wr_hpd) hpd_n = bus_wdata[0];
      if (wr_dpd) dpd_n = bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      srst_q <= 1'b0;
      hpd_q  <= 1'b1;
      dpd_q  <= 1'b0;
    end else begin
      srst_q <= srst_n;
      hpd_q  <= hpd_n;
      dpd_q  <= dpd_n;
    end
  end

  // port banks
  logic [SS_PORTS*PC_W-1:0] ss_ctl;
  logic [HS_PORTS*PC_W-1:0] hs_ctl;
  logic ss_pd_all, hs_pd_all;

  usbh_port_bank #(.NPORT(SS_PORTS), .BASE_W(W_SS_BASE), .WORD_W(WORD_W)) u_ss_bank (
    .clk(clk), .rst_n(rst_core_n), .srst(srst_q), .wr(bus_wr), .wword(word),
    .wbits(bus_wdata[PC_W-1:0]), .ctl_flat(ss_ctl), .pd_all(ss_pd_all));

  usbh_port_bank #(.NPORT(HS_PORTS), .BASE_W(W_HS_BASE), .WORD_W(WORD_W)) u_hs_bank (
    .clk(clk), .rst_n(rst_core_n), .srst(srst_q), .wr(bus_wr), .wword(word),
    .wbits(bus_wdata[PC_W-1:0]), .ctl_flat(hs_ctl), .pd_all(hs_pd_all));

  // power sequencing model
  logic pll_ok, ref_ok, sys_ok, ctl_ok, sleep;
  logic sleep_cond;
  assign sleep_cond = hpd_q && dpd_q && ss_pd_all && hs_pd_all;

  usbh_pwr_seq #(.PLL_DLY(PLL_DLY), .RST_STEP(RST_STEP), .SLEEP_DLY(SLEEP_DLY)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .srst(srst_q), .host_pd(hpd_q),
    .sleep_cond(sleep_cond), .pll_ok(pll_ok), .ref_ok(ref_ok),
    .sys_ok(sys_ok), .ctl_ok(ctl_ok), .sleep(sleep));

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (word == WORD_W'(W_SRST)) bus_rdata[0] = srst_q;
    if (word == WORD_W'(W_HPD))  bus_rdata[0] = hpd_q;
    if (word == WORD_W'(W_DPD))  bus_rdata[0] = dpd_q;
    if (word == WORD_W'(W_STS)) begin
      bus_rdata[STS_PLL] = pll_ok;
      bus_rdata[STS_REF] = ref_ok;
      bus_rdata[STS_SYS] = sys_ok;
      bus_rdata[STS_CTL] = ctl_ok;
      bus_rdata[STS_SLP] = sleep;
    end
    if (word == WORD_W'(W_CAP)) bus_rdata[15:0] = {8'(HS_PORTS), 8'(SS_PORTS)};
    for (int i = 0; i < SS_PORTS; i++)
      if (word == WORD_W'(W_SS_BASE + i)) bus_rdata[PC_W-1:0] = ss_ctl[i*PC_W +: PC_W];
    for (int i = 0; i < HS_PORTS; i++)
      if (word == WORD_W'(W_HS_BASE + i)) bus_rdata[PC_W-1:0] = hs_ctl[i*PC_W +: PC_W];
  end

  assert_ctrl_width_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (word == WORD_W'(W_HPD) || word == WORD_W'(W_DPD) || word == WORD_W'(W_SRST))
      |-> (bus_rdata[31:1] == '0));
  assert_cap_stable_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (word == WORD_W'(W_CAP) && $past(word == WORD_W'(W_CAP))) |-> $stable(bus_rdata));
  assert_srst_defaults_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    srst_q |=> (hpd_q && !dpd_q));
  assert_sleep_needs_pd_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_rdata[STS_SLP] && word == WORD_W'(W_STS) |-> (hpd_q && dpd_q));
endmodule

// File: tb/usbh_pwr_regs_tb_top.sv
module usbh_pwr_regs_tb_top;
  localparam int PLL_DLY = 64, STEP = 4, SLP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  usbh_pwr_regs #(.SS_PORTS(1), .HS_PORTS(2), .PLL_DLY(PLL_DLY), .RST_STEP(STEP),
                  .SLEEP_DLY(SLP), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // all tasks start and end at (or just after) a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #2;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    expect_rd("R1", 8'h00, 32'h0);
    expect_rd("R1", 8'h04, 32'h1);
    expect_rd("R1", 8'h08, 32'h0);
    expect_rd("R1", 8'h0C, 32'h0);
    expect_rd("R1", 8'h40, 32'h3);
    expect_rd("R1", 8'h60, 32'h3);
    expect_rd("R1", 8'h64, 32'h3);
  endtask

  task automatic t_cap();
    expect_rd("R2", 8'h10, 32'h0000_0201);
    bus_write(8'h10, 32'hFFFF_FFFF);
    expect_rd("R2", 8'h10, 32'h0000_0201);
  endtask

  task automatic t_ctrl();
    bus_write(8'h08, 32'hFFFF_FFFF);
    expect_rd("R3", 8'h08, 32'h1);
    bus_write(8'h08, 32'hFFFF_FFFE);
    expect_rd("R3", 8'h08, 32'h0);
  endtask

  task automatic t_ports();
    bus_write(8'h40, 32'hFFFF_FFF4);
    expect_rd("R4", 8'h40, 32'h4);
    bus_write(8'h64, 32'h5);
    expect_rd("R4", 8'h64, 32'h5);
    expect_rd("R4", 8'h60, 32'h3);
  endtask

  task automatic t_range();
    bus_write(8'h44, 32'h7);
    expect_rd("R5", 8'h44, 32'h0);
    bus_write(8'h68, 32'h7);
    expect_rd("R5", 8'h68, 32'h0);
    bus_write(8'h20, 32'hFFFF_FFFF);
    expect_rd("R5", 8'h20, 32'h0);
    expect_rd("R5", 8'h40, 32'h4);
  endtask

  task automatic t_powerup();
    bus_write(8'h04, 32'h0);
    wait_cyc(PLL_DLY - 1);
    expect_rd("R6", 8'h0C, 32'h0);
    wait_cyc(1);
    expect_rd("R6", 8'h0C, 32'h1);
    wait_cyc(STEP - 1);
    expect_rd("R7", 8'h0C, 32'h1);
    wait_cyc(1);
    expect_rd("R7", 8'h0C, 32'h101);
    wait_cyc(STEP);
    expect_rd("R7", 8'h0C, 32'h501);
    wait_cyc(STEP);
    expect_rd("R7", 8'h0C, 32'hD01);
    wait_cyc(10);
    expect_rd("R7", 8'h0C, 32'hD01);
  endtask

  task automatic t_pd_clear();
    bus_write(8'h04, 32'h1);
    expect_rd("R8", 8'h0C, 32'h0);
  endtask

  task automatic t_overlap();
    bus_write(8'h04, 32'h0);
    wait_cyc(PLL_DLY - 1);
    bus_write(8'h04, 32'h1);   // lands on the edge where PLL-stable would rise
    expect_rd("R8", 8'h0C, 32'h0);
    wait_cyc(PLL_DLY + 3*STEP + 2);
    expect_rd("R8", 8'h0C, 32'h0);
  endtask

  task automatic t_sleep();
    bus_write(8'h40, 32'h2);
    bus_write(8'h64, 32'h6);
    bus_write(8'h08, 32'h1);
    wait_cyc(SLP - 1);
    expect_rd("R9", 8'h0C, 32'h0);
    wait_cyc(1);
    expect_rd("R9", 8'h0C, 32'h4000_0000);
    bus_write(8'h64, 32'h4);
    expect_rd("R9", 8'h0C, 32'h0);
    bus_write(8'h64, 32'h6);
    wait_cyc(SLP);
    expect_rd("R9", 8'h0C, 32'h4000_0000);
    bus_write(8'h04, 32'h0);
    expect_rd("R9", 8'h0C, 32'h0);
  endtask

  task automatic t_srst();
    bus_write(8'h00, 32'h1);
    expect_rd("R10", 8'h00, 32'h1);
    wait_cyc(1);
    expect_rd("R10", 8'h04, 32'h1);
    expect_rd("R10", 8'h08, 32'h0);
    expect_rd("R10", 8'h40, 32'h3);
    expect_rd("R10", 8'h64, 32'h3);
    bus_write(8'h08, 32'h1);
    expect_rd("R10", 8'h08, 32'h0);
    bus_write(8'h00, 32'h0);
    expect_rd("R10", 8'h00, 32'h0);
    bus_write(8'h08, 32'h1);
    expect_rd("R10", 8'h08, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_cap();
    t_ctrl();
    t_ports();
    t_range();
    t_powerup();
    t_pd_clear();
    t_overlap();
    t_sleep();
    t_srst();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule